// File: doc/BRIEF.md
# Hash Input Block Aligner

This block sits between a byte-oriented data source and a hash core that only accepts whole 64-byte blocks, delivered as 32-bit words. Each update call announces its length, then streams its bytes in. Any bytes that would leave a block partly filled are held in a local 64-byte staging store and carried over to the next update. Only complete blocks of the cumulative stream reach the core.

Words are written into the core's input FIFO under a credit scheme. A fresh allowance of 32 words is granted whenever an update that will forward data begins. When the allowance runs out, the block samples the core's free-space count and waits until that count is nonzero. A 64-bit counter records the bytes actually delivered to the core. An init pulse clears that counter and the staging store between messages. Hash rounds and final padding belong to the core and its driver, not to this block.

Top module: `hash_block_aligner`

## Requirements
- R1: When the staged count plus the announced update length is below 64, every byte of the update is staged, no word is emitted, and the update ends with a one-cycle `updDone`.
- R2: Otherwise the update forwards F bytes, where F is the largest multiple of 64 not above (staged + length), minus the staged count. The staged bytes go first, then the first bytes of the update. Exactly F/4 + staged/4 words are emitted. Every byte past the forward point stays staged for the next update.
- R3: With 60 bytes staged, an update of 60 bytes emits 16 words: the 60 staged bytes followed by the first 4 new bytes. The other 56 new bytes remain staged.
- R4: Each word carries four consecutive stream bytes in little-endian order, with the earliest byte in bits 7:0 and the latest in bits 31:24. The words of a block appear in stream order.
- R5: The word credit is set to 32 when a forwarding update starts, and `coreEn` is high from the next cycle until the update finishes. When the credit is zero, no word is emitted; `fifoSpace` is sampled again, and emission resumes only once that sample is nonzero.
- R6: `byteCount` rises by exactly 4 in each cycle in which `wordValid` is high and never changes otherwise, except when cleared by init. It therefore excludes staged bytes.
- R7: An update whose staged count plus length exceeds 2^LEN_W - 1 is rejected. `updErr` pulses in the following cycle, and no byte is accepted, no word is emitted, and the staged content is kept.
- R8: A zero-length update raises `updDone` in the next cycle and changes neither the staged content nor `byteCount`.
- R9: An `initPulse` while idle clears `byteCount` to 0 and discards all staged bytes.
- R10: After reset, `inReady`, `wordValid`, `updDone`, `updErr` and `coreEn` are low and `byteCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| initPulse | input | 1 | Start of a new message: clears the counter and the staging store (honoured while idle) |
| updStart | input | 1 | One-cycle strobe that opens an update (honoured while idle) |
| updLen | input | LEN_W | Byte length of the update, sampled with `updStart` |
| inValid | input | 1 | Byte on `inByte` is valid |
| inByte | input | 8 | Stream byte |
| inReady | output | 1 | Block takes `inByte` at this edge when `inValid` is high |
| fifoSpace | input | SPACE_W | Free word slots reported by the core's input FIFO |
| coreEn | output | 1 | Core enabled for a forwarding update |
| wordValid | output | 1 | One word is written into the core FIFO this cycle |
| wordData | output | 32 | Word written into the core FIFO |
| byteCount | output | 64 | Bytes delivered to the core since init |
| updDone | output | 1 | One-cycle pulse: update complete |
| updErr | output | 1 | One-cycle pulse: update rejected |

## Verification
The assertions assume that `updStart` and `initPulse` arrive only while the block is idle and never in the same cycle. They also assume that an update supplies exactly the number of bytes it announced, and that `fifoSpace` never reports more than 32 slots. The stimulus tasks respect all of this: each scenario issues one start, streams exactly the announced byte count, and waits for `updDone` before the next start. Init is pulsed only between updates, and `fifoSpace` is held at values from 0 to 32. The credit scenario holds `fifoSpace` at zero long enough to show a stall, then releases it.

// File: rtl/hash_align_pkg.sv
package hash_align_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_FLUSH,
    ST_RELOAD
  } alignState_e;

  typedef struct packed {
    logic clrAll;        // new message: clear counter and staging
    logic armCredit;     // forwarding update starts: credit to initial value
    logic putByte;       // take the byte on the input into staging
    logic emitWord;      // push one staged word to the core
    logic reloadCredit;  // credit exhausted: sample the free-space field
    logic clrFill;       // whole block flushed: staging empty
  } alignStrobe_t;

endpackage

// File: rtl/hash_align_ctrl.sv
module hash_align_ctrl
  import hash_align_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int BLOCK_BYTES = 64,
  parameter int FILL_W      = 7,
  parameter int WIDX_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initPulse,
  input  logic              updStart,
  input  logic [LEN_W-1:0]  updLen,
  input  logic              inValid,
  input  logic [FILL_W-1:0] fill,
  input  logic              creditZero,
  output alignStrobe_t      strb,
  output logic [WIDX_W-1:0] wordIdx,
  output logic              inReady,
  output logic              coreEn,
  output logic              updDone,
  output logic              updErr
);

  localparam int SUM_W = LEN_W + 1;
  localparam int SHIFT = $clog2(BLOCK_BYTES);
  localparam int BLK_W = SUM_W - SHIFT;
  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(BLOCK_BYTES / 4 - 1);
  localparam logic [FILL_W-1:0] FULL_M1  = FILL_W'(BLOCK_BYTES - 1);

  alignState_e      state, nextState;
  logic [LEN_W-1:0] remaining;
  logic [BLK_W-1:0] blkLeft;   // whole blocks still to forward in this update
  logic [SUM_W-1:0] total;
  logic isIdle, doneNext, errNext, finish, lastWord, opening;

  assign isIdle   = (state == ST_IDLE);
  assign total    = {1'b0, updLen} + SUM_W'(fill);
  assign lastWord = (wordIdx == LAST_IDX);
  assign inReady  = (state == ST_FILL);
  assign opening  = isIdle && (nextState == ST_FILL);

  always_comb begin
    strb      = '0;
    nextState = state;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strb.clrAll = initPulse;
        if (updStart) begin
          if (updLen == '0) begin
            doneNext = 1'b1;
          end else if (total[LEN_W]) begin
            errNext = 1'b1;
          end else begin
            nextState      = ST_FILL;
            strb.armCredit = (total >= SUM_W'(BLOCK_BYTES));
          end
        end
      end
      ST_FILL: begin
        if (inValid) begin
          strb.putByte = 1'b1;
          if (fill == FULL_M1) nextState = ST_FLUSH;
          else if (remaining == LEN_W'(1)) finish = 1'b1;
        end
      end
      ST_FLUSH: begin
        if (creditZero) begin
          nextState = ST_RELOAD;
        end else begin
          strb.emitWord = 1'b1;
          if (lastWord) begin
            strb.clrFill = 1'b1;
            if (remaining == '0) finish = 1'b1;
            else nextState = ST_FILL;
          end
        end
      end
      ST_RELOAD: begin
        strb.reloadCredit = 1'b1;
        nextState         = ST_FLUSH;
      end
      default: nextState = ST_IDLE;
    endcase
    if (finish) begin
      nextState = ST_IDLE;
      doneNext  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      blkLeft   <= '0;
      wordIdx   <= '0;
      coreEn    <= 1'b0;
      updDone   <= 1'b0;
      updErr    <= 1'b0;
    end else begin
      state   <= nextState;
      updDone <= doneNext;
      updErr  <= errNext;
      if (opening) begin
        remaining <= updLen;
        blkLeft   <= BLK_W'(total >> SHIFT);
        coreEn    <= strb.armCredit;
        wordIdx   <= '0;
      end
      if (strb.putByte) remaining <= remaining - 1'b1;
      if (strb.emitWord) begin
        wordIdx <= wordIdx + 1'b1;
        if (lastWord) blkLeft <= blkLeft - 1'b1;
      end
      if (finish) coreEn <= 1'b0;
    end
  end

endmodule

// File: rtl/hash_align_dp.sv
module hash_align_dp
  import hash_align_pkg::*;
#(
  parameter int BLOCK_BYTES = 64,
  parameter int SPACE_W     = 6,
  parameter int CREDIT_INIT = 32,
  parameter int FILL_W      = 7,
  parameter int WIDX_W      = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  alignStrobe_t       strb,
  input  logic [7:0]         inByte,
  input  logic [WIDX_W-1:0]  wordIdx,
  input  logic [SPACE_W-1:0] fifoSpace,
  output logic [FILL_W-1:0]  fill,
  output logic               creditZero,
  output logic               wordValid,
  output logic [31:0]        wordData,
  output logic [63:0]        byteCount
);

  localparam int BLOCK_WORDS = BLOCK_BYTES / 4;
  localparam int IDX_W       = $clog2(BLOCK_BYTES);

  logic [7:0]         stage    [BLOCK_BYTES];
  logic [31:0]        wordView [BLOCK_WORDS];
  logic [SPACE_W-1:0] credit;

  // little-endian packing: earliest byte lands in the low lane
  for (genvar w = 0; w < BLOCK_WORDS; w++) begin : gWord
    assign wordView[w] = {stage[4*w+3], stage[4*w+2], stage[4*w+1], stage[4*w]};
  end

  assign creditZero = (credit == '0);

  always_ff @(posedge clk) begin
    if (strb.putByte) stage[fill[IDX_W-1:0]] <= inByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fill      <= '0;
      credit    <= '0;
      byteCount <= '0;
      wordValid <= 1'b0;
      wordData  <= '0;
    end else begin
      if (strb.clrAll || strb.clrFill) fill <= '0;
      else if (strb.putByte)           fill <= fill + 1'b1;

      if (strb.armCredit)         credit <= SPACE_W'(CREDIT_INIT);
      else if (strb.reloadCredit) credit <= fifoSpace;
      else if (strb.emitWord)     credit <= credit - 1'b1;

      if (strb.clrAll)        byteCount <= '0;
      else if (strb.emitWord) byteCount <= byteCount + 64'd4;

      wordValid <= strb.emitWord;
      if (strb.emitWord) wordData <= wordView[wordIdx];
    end
  end

endmodule

// File: rtl/hash_block_aligner.sv
module hash_block_aligner
  import hash_align_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int BLOCK_BYTES = 64,
  parameter int SPACE_W     = 6,
  parameter int CREDIT_INIT = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               initPulse,
  input  logic               updStart,
  input  logic [LEN_W-1:0]   updLen,
  input  logic               inValid,
  input  logic [7:0]         inByte,
  output logic               inReady,
  input  logic [SPACE_W-1:0] fifoSpace,
  output logic               coreEn,
  output logic               wordValid,
  output logic [31:0]        wordData,
  output logic [63:0]        byteCount,
  output logic               updDone,
  output logic               updErr
);

  localparam int FILL_W = $clog2(BLOCK_BYTES + 1);
  localparam int WIDX_W = $clog2(BLOCK_BYTES / 4);

  alignStrobe_t      strb;
  logic [FILL_W-1:0] fill;
  logic [WIDX_W-1:0] wordIdx;
  logic              creditZero;

  hash_align_ctrl #(
    .LEN_W(LEN_W), .BLOCK_BYTES(BLOCK_BYTES), .FILL_W(FILL_W), .WIDX_W(WIDX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .updStart(updStart),
    .updLen(updLen), .inValid(inValid), .fill(fill), .creditZero(creditZero),
    .strb(strb), .wordIdx(wordIdx), .inReady(inReady), .coreEn(coreEn),
    .updDone(updDone), .updErr(updErr)
  );

  hash_align_dp #(
    .BLOCK_BYTES(BLOCK_BYTES), .SPACE_W(SPACE_W), .CREDIT_INIT(CREDIT_INIT),
    .FILL_W(FILL_W), .WIDX_W(WIDX_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inByte(inByte), .wordIdx(wordIdx),
    .fifoSpace(fifoSpace), .fill(fill), .creditZero(creditZero),
    .wordValid(wordValid), .wordData(wordData), .byteCount(byteCount)
  );

endmodule

// File: rtl/hash_align_checker.sv
module hash_align_checker #(
  parameter int LEN_W       = 16,
  parameter int FILL_W      = 7,
  parameter int BLOCK_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              initPulse,
  input logic              updStart,
  input logic [LEN_W-1:0]  updLen,
  input logic              coreEn,
  input logic              wordValid,
  input logic [63:0]       byteCount,
  input logic              updDone,
  input logic              updErr,
  input logic [FILL_W-1:0] fill,
  input logic              creditZero,
  input logic              blkZero,
  input logic              isIdle
);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FILL_W'(BLOCK_BYTES)); // R1

  AST_BLOCKS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    updDone |-> blkZero); // R2

  AST_NO_WORD_NO_CREDIT: assert property (@(posedge clk) disable iff (!rstN)
    creditZero |=> !wordValid); // R5

  AST_WORD_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(coreEn)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> byteCount == $past(byteCount) + 64'd4); // R6

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wordValid && !$past(initPulse)) |-> $stable(byteCount)); // R6

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(updDone && updErr)); // R7

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(updStart) && $past(updLen) == '0 && $past(isIdle))
      |-> (updDone && $stable(byteCount))); // R8

endmodule

bind hash_block_aligner hash_align_checker #(
  .LEN_W(LEN_W), .FILL_W(FILL_W), .BLOCK_BYTES(BLOCK_BYTES)
) uChk (
  .clk(clk), .rstN(rstN), .initPulse(initPulse), .updStart(updStart),
  .updLen(updLen), .coreEn(coreEn), .wordValid(wordValid),
  .byteCount(byteCount), .updDone(updDone), .updErr(updErr), .fill(fill),
  .creditZero(creditZero), .blkZero(uCtrl.blkLeft == '0),
  .isIdle(uCtrl.isIdle)
);

// File: tb/sim_hash_block_aligner.sv
module sim_hash_block_aligner;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initPulse = 1'b0;
  logic        updStart = 1'b0;
  logic [15:0] updLen = '0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inReady;
  logic [5:0]  fifoSpace = 6'd32;
  logic        coreEn, wordValid, updDone, updErr;
  logic [31:0] wordData;
  logic [63:0] byteCount;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hash_block_aligner u0 (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .updStart(updStart),
    .updLen(updLen), .inValid(inValid), .inByte(inByte), .inReady(inReady),
    .fifoSpace(fifoSpace), .coreEn(coreEn), .wordValid(wordValid),
    .wordData(wordData), .byteCount(byteCount), .updDone(updDone),
    .updErr(updErr)
  );

  int checks = 0;
  int fails = 0;
  int wordCnt = 0;
  int doneCnt = 0;
  int errCnt = 0;
  bit finished = 0;

  // reference model of the requirements: staged bytes and expected words
  logic [7:0]      mStage[64];
  int              mFill = 0;
  int unsigned     expQ[$];
  longint unsigned mBytes = 0;
  logic [31:0]     monExp;

  function automatic void modelPush(logic [7:0] b);
    mStage[mFill] = b;
    mFill++;
    if (mFill == 64) begin
      for (int k = 0; k < 16; k++)
        expQ.push_back({mStage[4*k+3], mStage[4*k+2], mStage[4*k+1], mStage[4*k]});
      mFill = 0;
      mBytes += 64;
    end
  endfunction

  task automatic check(bit ok, string req, string what,
                       longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // word monitor: R4 data order and packing
  always @(negedge clk) begin
    if (rstN) begin
      if (updDone) doneCnt++;
      if (updErr) errCnt++;
      if (wordValid) begin
        wordCnt++;
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R4 unexpected word act=%h exp=none", wordData);
        end else begin
          monExp = expQ.pop_front();
          if (wordData !== monExp) begin
            fails++;
            $display("FAIL R4 word data act=%h exp=%h", wordData, monExp);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete act=hung exp=done");
    finishRun();
  end

  task automatic startUpd(int n);
    @(negedge clk);
    updStart = 1'b1;
    updLen   = 16'(n);
    @(negedge clk);
    updStart = 1'b0;
    updLen   = '0;
  endtask

  task automatic sendBytes(int n, int seed);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      inValid = 1'b1;
      inByte  = 8'(seed + 7 * i);
      #1;
      if (inReady) begin
        modelPush(inByte);
        i++;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitDone(int d0, string req);
    int t = 0;
    while (doneCnt == d0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(doneCnt > d0, req, "update done seen", doneCnt - d0, 1);
  endtask

  task automatic doUpdate(int n, int seed, string req);
    int w0 = wordCnt;
    int d0 = doneCnt;
    int s  = mFill;
    int expWords = ((s + n) / 64) * 16;   // forward point is a multiple of 64
    startUpd(n);
    sendBytes(n, seed);
    waitDone(d0, req);
    @(negedge clk);
    check(wordCnt - w0 == expWords, req, "words emitted", wordCnt - w0, expWords);
    check(expQ.size() == 0, req, "pending expected words", expQ.size(), 0);
    check(byteCount == mBytes, "R6", "byteCount after update", byteCount, mBytes);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(inReady == 0 && wordValid == 0 && updDone == 0 && updErr == 0 && coreEn == 0,
          "R10", "control outputs in reset", {inReady, wordValid, updDone, updErr, coreEn}, 0);
    check(byteCount == 0, "R10", "byteCount in reset", byteCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 0 && wordValid == 0, "R10", "idle after reset", {inReady, wordValid}, 0);
  endtask

  task automatic testStageOnly();
    doUpdate(20, 3, "R1");
    doUpdate(40, 50, "R1");
    check(mFill == 60, "R1", "model staged count", mFill, 60);
  endtask

  task automatic testWorkedCase();
    doUpdate(60, 100, "R3");       // 60 staged + 4 new forwarded, 56 kept
    check(mFill == 56, "R3", "bytes left staged", mFill, 56);
    doUpdate(8, 200, "R3");        // 56 + 8 completes the next block
    check(byteCount == 128, "R6", "byteCount after two blocks", byteCount, 128);
  endtask

  task automatic testMultiBlock();
    doUpdate(130, 11, "R2");       // two blocks out, two bytes kept
    check(mFill == 2, "R2", "tail staged", mFill, 2);
  endtask

  task automatic testZeroLen();
    int w0 = wordCnt;
    longint unsigned bc = byteCount;
    @(negedge clk);
    updStart = 1'b1;
    updLen   = '0;
    @(negedge clk);
    updStart = 1'b0;
    check(updDone == 1, "R8", "done one cycle after start", updDone, 1);
    @(negedge clk);
    check(updDone == 0, "R8", "done is a single pulse", updDone, 0);
    check(wordCnt == w0, "R8", "no words", wordCnt - w0, 0);
    check(byteCount == bc, "R8", "byteCount unchanged", byteCount, bc);
  endtask

  task automatic testReject();
    int w0 = wordCnt;
    int d0 = doneCnt;
    longint unsigned bc = byteCount;
    startUpd(65534);               // 2 staged + 65534 exceeds 16-bit range
    check(updErr == 1, "R7", "error pulse next cycle", updErr, 1);
    @(negedge clk);
    check(inReady == 0, "R7", "no bytes taken", inReady, 0);
    check(doneCnt == d0, "R7", "no done", doneCnt - d0, 0);
    check(wordCnt == w0 && byteCount == bc, "R7", "no words or count change",
          wordCnt - w0, 0);
    doUpdate(62, 77, "R7");        // staged 2 bytes still lead the block
  endtask

  task automatic testCredit();
    int w0 = wordCnt;
    int d0 = doneCnt;
    fifoSpace = 6'd0;
    startUpd(192);
    sendBytes(192, 9);
    repeat (50) @(negedge clk);
    check(wordCnt - w0 == 32, "R5", "words before credit refill", wordCnt - w0, 32);
    check(coreEn == 1, "R5", "core enabled while stalled", coreEn, 1);
    check(doneCnt == d0, "R5", "stalled update not done", doneCnt - d0, 0);
    fifoSpace = 6'd5;
    waitDone(d0, "R5");
    @(negedge clk);
    check(wordCnt - w0 == 48, "R5", "words after refill", wordCnt - w0, 48);
    check(coreEn == 0, "R5", "core released after update", coreEn, 0);
    check(byteCount == mBytes, "R6", "byteCount after stall", byteCount, mBytes);
    fifoSpace = 6'd0;              // fresh 32 credits at next forwarding start
    doUpdate(128, 31, "R5");
    fifoSpace = 6'd32;
  endtask

  task automatic testInit();
    doUpdate(30, 60, "R1");
    @(negedge clk);
    initPulse = 1'b1;
    @(negedge clk);
    initPulse = 1'b0;
    mFill  = 0;
    mBytes = 0;
    check(byteCount == 0, "R9", "byteCount cleared", byteCount, 0);
    doUpdate(64, 140, "R9");       // words hold only new bytes
  endtask

  initial begin
    testReset();
    testStageOnly();
    testWorkedCase();
    testMultiBlock();
    testZeroLen();
    testReject();
    testCredit();
    testInit();
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule